// File: doc/BRIEF.md
# Delay Window Best-Phase Selector

This block picks a sampling delay for a tunable input path. Software or a tuning sequencer sweeps a delay line over every cell, records for each setting whether a test transfer succeeded, and hands the resulting pass/fail map to this block. The block scans the map and finds the widest stretch of neighbouring passing settings. It reports where that stretch begins, how wide it is, and one delay value inside it to program as the final setting.

A one-cycle start pulse launches a sequential scan of the map, one cell per clock. A one-cycle done pulse marks the result. The scan stops early when it has found a wide window close to the zero end of the delay line. When the chosen window begins at cell zero, the selected point moves toward the short-delay side instead of sitting at the centre. An empty map gives a reserved failure code in place of a delay.

Top module: `dwps_top`

## Requirements
- R1: While the block is idle, a start pulse latches `map_i`. Exactly one `done_o` pulse, one cycle wide, follows within CELLS+2 clock cycles of that pulse.
- R2: A map with no bit set gives `phase_o` = 0xFF (all ones of PHASE_W bits), `win_start_o` = 0 and `win_len_o` = 0.
- R3: Bit i of the map is the result for delay cell i, and 1 means pass. A window is a run of consecutive 1 bits counted upward from its first cell. A window ends at the first 0 bit or at cell CELLS-1 and never wraps from cell CELLS-1 to cell 0. The reported window is the longest one scanned.
- R4: When two windows have equal length, the one at the lower index is kept.
- R5: The scan stops as soon as a window of EARLY_LEN (8) or more cells has ended while the best window's start is below EARLY_START (4). No later window is considered, even a longer one.
- R6: If the reported window starts at cell 0, `phase_o` = floor(length/3) mod CELLS.
- R7: If the reported window starts at any other cell, `phase_o` = (start + floor(length/2)) mod CELLS.
- R8: `win_start_o`, `win_len_o` and `phase_o` change only in the cycle `done_o` is high and hold their values otherwise. A start pulse that arrives during a scan is ignored.
- R9: After reset, `done_o` = 0, `phase_o` = 0xFF, `win_start_o` = 0 and `win_len_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to evaluate `map_i` |
| map_i | input | CELLS | Pass/fail map, bit i for delay cell i |
| done_o | output | 1 | One-cycle pulse when results are updated |
| win_start_o | output | $clog2(CELLS) | First cell of the chosen window |
| win_len_o | output | $clog2(CELLS+1) | Length of the chosen window |
| phase_o | output | PHASE_W | Selected delay, or all ones when no cell passed |

## Verification
The early-exit rule is the hardest thing to observe, because it leaves no trace unless a later and strictly longer window would otherwise have won. The stimulus places an eight-cell window at start 2 or 3 ahead of a twenty-cell window, and the smaller window must be reported. Near-miss maps sit beside these: a window at start 4, and a seven-cell window at start 0. In both, the longer window further up must still win. Start pulses issued mid-scan, and maps that change after the start, show that the result comes only from the latched map.

// File: rtl/dwps_pkg.sv
package dwps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_FINISH
  } scan_state_e;
endpackage

// File: rtl/dwps_ctrl.sv
module dwps_ctrl #(
  parameter int CELLS = 32,
  parameter int IDX_W = $clog2(CELLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CELLS-1:0] map_i,
  input  logic             stop_i,
  output logic             clear_o,
  output logic             scan_o,
  output logic             finish_o,
  output logic             bit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  import dwps_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELLS - 1);

  scan_state_e      state_q;
  logic [CELLS-1:0] map_q;
  logic [IDX_W-1:0] idx_q;

  assign clear_o  = (state_q == ST_IDLE) && start_i;
  assign scan_o   = (state_q == ST_SCAN);
  assign finish_o = (state_q == ST_FINISH);
  assign bit_o    = map_q[idx_q];
  assign idx_o    = idx_q;
  assign last_o   = (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      map_q   <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            map_q   <= map_i;
            idx_q   <= '0;
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (stop_i || last_o) begin
            state_q <= ST_FINISH;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1: finish lasts one cycle, scan ends after the last cell
  p_finish_single_r1: assert property (@(posedge clk) disable iff (rst)
    finish_o |=> !finish_o);
  p_scan_bounded_r1: assert property (@(posedge clk) disable iff (rst)
    (scan_o && last_o) |=> finish_o);
  // R5: an early stop request ends the scan on the next edge
  p_early_stop_r5: assert property (@(posedge clk) disable iff (rst)
    (scan_o && stop_i) |=> !scan_o);
  // R8: a start during a scan does not reload the map
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (rst)
    (scan_o && start_i) |=> $stable(map_q));
endmodule

// File: rtl/dwps_run_track.sv
module dwps_run_track #(
  parameter int CELLS = 32,
  parameter int IDX_W = $clog2(CELLS),
  parameter int LEN_W = $clog2(CELLS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             bit_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             last_i,
  output logic             ev_o,
  output logic [IDX_W-1:0] ev_start_o,
  output logic [LEN_W-1:0] ev_len_o
);
  logic [IDX_W-1:0] run_start_q;
  logic [LEN_W-1:0] run_len_q;

  always_comb begin
    ev_start_o = (run_len_q == '0) ? idx_i : run_start_q;
    ev_len_o   = bit_i ? (run_len_q + LEN_W'(1)) : run_len_q;
    ev_o       = step_i && ((!bit_i && (run_len_q != '0)) || (bit_i && last_i));
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      run_start_q <= '0;
      run_len_q   <= '0;
    end else if (step_i) begin
      if (bit_i) begin
        run_len_q <= run_len_q + LEN_W'(1);
        if (run_len_q == '0) run_start_q <= idx_i;
      end else begin
        run_len_q <= '0;
      end
    end
  end

  // R3: a run never extends past the top cell (no wrap)
  p_run_fits_r3: assert property (@(posedge clk) disable iff (rst)
    (run_len_q != '0) |-> ((32'(run_start_q) + 32'(run_len_q)) <= 32'(CELLS)));
endmodule

// File: rtl/dwps_best_keep.sv
module dwps_best_keep #(
  parameter int CELLS       = 32,
  parameter int IDX_W       = $clog2(CELLS),
  parameter int LEN_W       = $clog2(CELLS + 1),
  parameter int EARLY_LEN   = 8,
  parameter int EARLY_START = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             ev_i,
  input  logic [IDX_W-1:0] ev_start_i,
  input  logic [LEN_W-1:0] ev_len_i,
  output logic [IDX_W-1:0] best_start_o,
  output logic [LEN_W-1:0] best_len_o,
  output logic             stop_o
);
  logic             take;
  logic [IDX_W-1:0] next_start;

  always_comb begin
    take       = ev_i && (ev_len_i > best_len_o);
    next_start = take ? ev_start_i : best_start_o;
    stop_o     = ev_i && (32'(ev_len_i) >= 32'(EARLY_LEN)) &&
                 (32'(next_start) < 32'(EARLY_START));
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      best_start_o <= '0;
      best_len_o   <= '0;
    end else if (take) begin
      best_start_o <= ev_start_i;
      best_len_o   <= ev_len_i;
    end
  end

  // R3: the best length never shrinks within a scan
  p_best_grows_r3: assert property (@(posedge clk) disable iff (rst)
    !clear_i |=> (best_len_o >= $past(best_len_o)));
  // R4: a run no longer than the best leaves the best start alone
  p_tie_keeps_r4: assert property (@(posedge clk) disable iff (rst)
    (ev_i && !clear_i && (ev_len_i <= best_len_o)) |=> $stable(best_start_o));
endmodule

// File: rtl/dwps_phase_calc.sv
module dwps_phase_calc #(
  parameter int CELLS   = 32,
  parameter int IDX_W   = $clog2(CELLS),
  parameter int LEN_W   = $clog2(CELLS + 1),
  parameter int PHASE_W = 8
) (
  input  logic [IDX_W-1:0]   best_start_i,
  input  logic [LEN_W-1:0]   best_len_i,
  output logic [PHASE_W-1:0] phase_o
);
  always_comb begin
    int s;
    int l;
    int v;
    s = int'(best_start_i);
    l = int'(best_len_i);
    if (l == 0) begin
      v = 0;
      phase_o = '1;
    end else begin
      if (s == 0) v = l / 3;
      else        v = s + l / 2;
      v = v % CELLS;
      phase_o = PHASE_W'(v);
    end
  end
endmodule

// File: rtl/dwps_top.sv
module dwps_top #(
  parameter int CELLS       = 32,
  parameter int PHASE_W     = 8,
  parameter int EARLY_LEN   = 8,
  parameter int EARLY_START = 4,
  parameter int IDX_W       = $clog2(CELLS),
  parameter int LEN_W       = $clog2(CELLS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [CELLS-1:0]   map_i,
  output logic               done_o,
  output logic [IDX_W-1:0]   win_start_o,
  output logic [LEN_W-1:0]   win_len_o,
  output logic [PHASE_W-1:0] phase_o
);
  logic             clear, scan, finish, cell_bit, last, stop, ev;
  logic [IDX_W-1:0] idx, ev_start, best_start;
  logic [LEN_W-1:0] ev_len, best_len;
  logic [PHASE_W-1:0] phase_next;

  dwps_ctrl #(.CELLS(CELLS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .map_i(map_i), .stop_i(stop),
    .clear_o(clear), .scan_o(scan), .finish_o(finish), .bit_o(cell_bit),
    .idx_o(idx), .last_o(last)
  );

  dwps_run_track #(.CELLS(CELLS), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_run (
    .clk(clk), .rst(rst), .clear_i(clear), .step_i(scan), .bit_i(cell_bit),
    .idx_i(idx), .last_i(last), .ev_o(ev), .ev_start_o(ev_start), .ev_len_o(ev_len)
  );

  dwps_best_keep #(.CELLS(CELLS), .IDX_W(IDX_W), .LEN_W(LEN_W),
                   .EARLY_LEN(EARLY_LEN), .EARLY_START(EARLY_START)) u_best (
    .clk(clk), .rst(rst), .clear_i(clear), .ev_i(ev), .ev_start_i(ev_start),
    .ev_len_i(ev_len), .best_start_o(best_start), .best_len_o(best_len), .stop_o(stop)
  );

  dwps_phase_calc #(.CELLS(CELLS), .IDX_W(IDX_W), .LEN_W(LEN_W),
                    .PHASE_W(PHASE_W)) u_phase (
    .best_start_i(best_start), .best_len_i(best_len), .phase_o(phase_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o      <= 1'b0;
      win_start_o <= '0;
      win_len_o   <= '0;
      phase_o     <= '1;
    end else begin
      done_o <= finish;
      if (finish) begin
        win_start_o <= best_start;
        win_len_o   <= best_len;
        phase_o     <= phase_next;
      end
    end
  end

  // R1: done is a single-cycle pulse
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R2: failure code appears exactly when no window was found
  p_fail_code_r2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ((phase_o == {PHASE_W{1'b1}}) == (win_len_o == '0)));
  // R7: a real phase is always a legal cell index
  p_phase_range_r7: assert property (@(posedge clk) disable iff (rst)
    (done_o && (win_len_o != '0)) |-> (32'(phase_o) < 32'(CELLS)));
  // R8: results hold between done pulses
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !finish |=> ($stable(phase_o) && $stable(win_len_o) && $stable(win_start_o)));
endmodule

// File: tb/dwps_top_tb.sv
module dwps_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] map_i = '0;
  logic        done_o;
  logic [4:0]  win_start_o;
  logic [5:0]  win_len_o;
  logic [7:0]  phase_o;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  dwps_top u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .map_i(map_i), .done_o(done_o),
    .win_start_o(win_start_o), .win_len_o(win_len_o), .phase_o(phase_o)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  function automatic void model(input logic [31:0] m, output int bs, output int bl, output int ph);
    int s;
    int l;
    bs = 0; bl = 0; s = 0;
    if (m == 32'h0) begin
      ph = 255;
      return;
    end
    while (s < 32) begin
      l = 0;
      while ((s + l) < 32 && m[s + l]) l++;
      if (bl < l) begin bs = s; bl = l; end
      s += (l != 0) ? l : 1;
      if (l >= 8 && bs < 4) break;
    end
    ph = (bs == 0) ? (bl / 3) % 32 : (bs + bl / 2) % 32;
  endfunction

  // Launch a scan and wait for done; returns latency in cycles.
  task automatic launch(input logic [31:0] m, output int lat);
    @(negedge clk);
    map_i = m; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_case(input string req, input logic [31:0] m,
                          input int es, input int el, input int ep);
    int lat;
    launch(m, lat);
    check("R1", "done seen", int'(done_o), 1);
    check("R1", "latency bound", int'(lat <= 34), 1);
    check(req, "win_start", int'(win_start_o), es);
    check(req, "win_len", int'(win_len_o), el);
    check(req, "phase", int'(phase_o), ep);
    @(negedge clk);
    check("R1", "done one cycle", int'(done_o), 0);
  endtask

  task automatic test_reset();
    check("R9", "done after reset", int'(done_o), 0);
    check("R9", "phase after reset", int'(phase_o), 255);
    check("R9", "start after reset", int'(win_start_o), 0);
    check("R9", "len after reset", int'(win_len_o), 0);
  endtask

  task automatic test_all_fail();      run_case("R2", 32'h0000_0000, 0, 0, 255);  endtask
  task automatic test_all_pass();      run_case("R6", 32'hFFFF_FFFF, 0, 32, 10);  endtask
  task automatic test_zero_bias();     run_case("R6", 32'h0000_007F, 0, 7, 2);    endtask
  task automatic test_top_cell();      run_case("R7", 32'h8000_0000, 31, 1, 31);  endtask
  task automatic test_no_wrap();       run_case("R3", 32'h8000_0001, 0, 1, 0);    endtask
  task automatic test_longest_high();  run_case("R3", 32'hF000_0003, 28, 4, 30);  endtask
  task automatic test_tie();           run_case("R4", 32'h0000_1C70, 4, 3, 5);    endtask
  task automatic test_early_at2();     run_case("R5", 32'hFFFF_F3FC, 2, 8, 6);    endtask
  task automatic test_early_at3();     run_case("R5", 32'hFFFF_F7F8, 3, 8, 7);    endtask
  task automatic test_no_early_at4();  run_case("R5", 32'hFFFF_EFF0, 13, 19, 22); endtask
  task automatic test_short_at0();     run_case("R5", 32'h0FFF_FF7F, 8, 20, 18);  endtask
  task automatic test_midpoint();      run_case("R7", 32'h03FF_DFEE, 14, 12, 20); endtask

  task automatic test_hold_ignore();
    int lat;
    int cnt;
    @(negedge clk);
    map_i = 32'h0000_1C70; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cnt = 0;
    repeat (3) begin @(negedge clk); if (done_o) cnt++; end
    map_i = 32'hFFFF_FFFF; start_i = 1'b1;
    @(negedge clk);
    if (done_o) cnt++;
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 40) begin @(negedge clk); lat++; end
    if (done_o) cnt++;
    check("R8", "mid-scan start ignored start", int'(win_start_o), 4);
    check("R8", "mid-scan start ignored len", int'(win_len_o), 3);
    repeat (40) begin @(negedge clk); if (done_o) cnt++; end
    check("R8", "single done for overlapping starts", cnt, 1);
    check("R8", "phase held", int'(phase_o), 5);
    check("R8", "len held", int'(win_len_o), 3);
  endtask

  task automatic test_random();
    logic [31:0] x;
    logic [31:0] m;
    int es, el, ep;
    x = 32'h1357_9BDF;
    for (int i = 0; i < 40; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      m = (i % 3 == 0) ? x : ((i % 3 == 1) ? (x | (x >> 1)) : (x & (x >> 2)));
      model(m, es, el, ep);
      run_case((es == 0) ? "R6" : "R7", m, es, el, ep);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_all_fail();
    test_all_pass();
    test_zero_bias();
    test_top_cell();
    test_no_wrap();
    test_longest_high();
    test_tie();
    test_early_at2();
    test_early_at3();
    test_no_early_at4();
    test_short_at0();
    test_midpoint();
    test_hold_ignore();
    test_random();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule